// File: doc/BRIEF.md
# Recirculating 64-Stage Serial Delay Line

This block is a static serial-in, serial-out shift register with a fixed length of 64 stages. Each rising clock edge moves every stored bit one stage along. A fresh bit enters the first stage on the same edge. A select input picks the source of that fresh bit. It is either the external serial data input or a second serial input meant for feedback. The last stage is brought out in true and inverted form.

There are two common uses. Chaining the true output of one instance into the data input of the next gives a delay that is a multiple of 64 clocks. Tying the true output back to the feedback input and holding the select high keeps a 64-bit word circulating for as long as the clock runs. A synchronous active-high reset empties every stage.

Top module: `recirc_shift64`

## Requirements
- R1: A bit captured into the first stage on rising edge k appears on `q_out` right after rising edge k+63. This is 64 edges counted from its own capture edge. Stages that have not yet received data since reset read 0.
- R2: When `loop_sel` is 0 at a rising edge, the first stage captures `data_in`, and `recirc_in` has no effect on the stored data.
- R3: When `loop_sel` is 1 at a rising edge, the first stage captures `recirc_in`, and `data_in` has no effect on the stored data.
- R4: Whenever the block is out of reset, `q_out_n` equals the inverse of `q_out`.
- R5: Each edge moves every bit exactly one stage. The output of the final stage is therefore the value the previous stage held before that edge. Two instances in series, with the first instance's `q_out` driving the second's `data_in` and `loop_sel` at 0, delay a bit by 128 edges.
- R6: A rising edge with `rst` at 1 clears all 64 stages. Right after that edge, `q_out` is 0 and `q_out_n` is 1, and they stay so until data arrives at the output.
- R7: With `q_out` wired to `recirc_in` and `loop_sel` held at 1, a loaded 64-bit pattern repeats on `q_out` every 64 edges, without loss, for any number of loops.
- R8: `loop_sel` is sampled on the same edge as the data. Changing it between adjacent edges switches the source for exactly the bits captured on those edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock, rising edge active |
| rst | input | 1 | Synchronous active-high clear of all stages |
| data_in | input | 1 | External serial data input |
| recirc_in | input | 1 | Feedback serial input |
| loop_sel | input | 1 | Source select: 0 takes data_in, 1 takes recirc_in |
| q_out | output | 1 | Final stage, true form |
| q_out_n | output | 1 | Final stage, inverted form |

## Verification
The bench targets the exact latency boundary. A design one stage short or one stage long would show each random bit a cycle early or late, and this fails R1 on the first non-zero bit. Feeding opposite random streams to the two inputs and toggling the select every cycle exposes an inverted or late-sampled select, because the stored bits would come from the wrong stream. Three full loops of a loaded pattern would catch a lost or doubled bit in the feedback path. A reset applied mid-stream, followed by watching 64 outputs, would catch a stage left uncleared.

// File: rtl/recirc_pkg.sv
package recirc_pkg;
  localparam int unsigned RSR_DEPTH_DEFAULT = 64;

  typedef enum logic {
    SRC_DATA = 1'b0,
    SRC_LOOP = 1'b1
  } src_sel_e;
endpackage

// File: rtl/recirc_src_sel.sv
module recirc_src_sel
  import recirc_pkg::*;
(
  input  logic sel_i,
  input  logic data_i,
  input  logic loop_i,
  output logic bit_o
);
  src_sel_e src;

  always_comb begin
    src = src_sel_e'(sel_i);
    unique case (src)
      SRC_LOOP: bit_o = loop_i;
      default:  bit_o = data_i;
    endcase
  end
endmodule

// File: rtl/recirc_stage_chain.sv
module recirc_stage_chain #(
  parameter int unsigned LEN = 63
) (
  input  logic clk,
  input  logic rst,
  input  logic ser_i,
  output logic head_o,
  output logic tail_o
);
  logic [LEN-1:0] stg_q;

  for (genvar i = 0; i < LEN; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg_q[i] <= 1'b0;
        else     stg_q[i] <= ser_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg_q[i] <= 1'b0;
        else     stg_q[i] <= stg_q[i-1];
      end
    end
  end

  assign head_o = stg_q[0];
  assign tail_o = stg_q[LEN-1];
endmodule

// File: rtl/recirc_out_stage.sv
module recirc_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic tail_i,
  output logic q_o,
  output logic qn_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_o  <= 1'b0;
      qn_o <= 1'b1;
    end else begin
      q_o  <= tail_i;
      qn_o <= ~tail_i;
    end
  end

  // R4: both output flops always disagree
  p_compl_r4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (qn_o == ~q_o));

  // R5: final stage takes what the previous stage held
  p_tail_step_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (q_o == $past(tail_i)));

  // R6: reset leaves a cleared output pair
  p_reset_out_r6: assert property (@(posedge clk)
    rst |=> (q_o == 1'b0 && qn_o == 1'b1));
endmodule

// File: rtl/recirc_shift64.sv
module recirc_shift64
  import recirc_pkg::*;
#(
  parameter int unsigned DEPTH = RSR_DEPTH_DEFAULT
) (
  input  logic clk,
  input  logic rst,
  input  logic data_in,
  input  logic recirc_in,
  input  logic loop_sel,
  output logic q_out,
  output logic q_out_n
);
  localparam int unsigned CHAIN_LEN = DEPTH - 1;

  logic ser_bit;
  logic head_q;
  logic tail_q;

  recirc_src_sel u_sel (
    .sel_i  (loop_sel),
    .data_i (data_in),
    .loop_i (recirc_in),
    .bit_o  (ser_bit)
  );

  recirc_stage_chain #(.LEN(CHAIN_LEN)) u_chain (
    .clk    (clk),
    .rst    (rst),
    .ser_i  (ser_bit),
    .head_o (head_q),
    .tail_o (tail_q)
  );

  recirc_out_stage u_out (
    .clk  (clk),
    .rst  (rst),
    .tail_i (tail_q),
    .q_o  (q_out),
    .qn_o (q_out_n)
  );

  // R2: select low loads the external input
  p_head_data_r2: assert property (@(posedge clk) disable iff (rst)
    !loop_sel |=> (head_q == $past(data_in)));

  // R3: select high loads the feedback input
  p_head_loop_r3: assert property (@(posedge clk) disable iff (rst)
    loop_sel |=> (head_q == $past(recirc_in)));

  // R6: reset empties the first stage too
  p_reset_head_r6: assert property (@(posedge clk)
    rst |=> (head_q == 1'b0));
endmodule

// File: tb/recirc_shift64_tb.sv
module recirc_shift64_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;
  localparam int HMAX = 4096;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic data_in = 1'b0;
  logic rec_drv = 1'b0;
  logic loop_sel = 1'b0;
  logic loop_wire = 1'b0;
  logic recirc_in;
  logic q_out, q_out_n, q2_out, q2_out_n;

  int checks = 0;
  int errors = 0;
  int n = 0;
  logic hist [HMAX];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign recirc_in = loop_wire ? q_out : rec_drv;

  recirc_shift64 u_dut (
    .clk(clk), .rst(rst), .data_in(data_in), .recirc_in(recirc_in),
    .loop_sel(loop_sel), .q_out(q_out), .q_out_n(q_out_n)
  );

  recirc_shift64 u_dut2 (
    .clk(clk), .rst(rst), .data_in(q_out), .recirc_in(1'b0),
    .loop_sel(1'b0), .q_out(q2_out), .q_out_n(q2_out_n)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b (edge %0d)", req, act, exp, n);
    end
  endtask

  function automatic logic exp_at(input int back);
    return (n - back >= 1) ? hist[n - back - 1] : 1'b0;
  endfunction

  // One clock: drive at negedge, step, check at next negedge
  task automatic step(input logic d, input logic m, input logic r, input string req);
    logic eff;
    data_in  = d;
    loop_sel = m;
    rec_drv  = r;
    eff = m ? (loop_wire ? q_out : r) : d;
    if (n < HMAX) hist[n] = eff;
    @(posedge clk);
    n++;
    @(negedge clk);
    chk(req, q_out, exp_at(63));
    chk("R4", q_out_n, ~q_out);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    n = 0;
    chk("R6", q_out, 1'b0);
    chk("R6", q_out_n, 1'b1);
  endtask

  task automatic t_latency_data();
    do_reset();
    for (int i = 0; i < 200; i++) step($urandom_range(0,1), 1'b0, $urandom_range(0,1), "R1/R2");
  endtask

  task automatic t_loop_input();
    do_reset();
    for (int i = 0; i < 150; i++) step($urandom_range(0,1), 1'b1, $urandom_range(0,1), "R3");
  endtask

  task automatic t_mode_toggle();
    do_reset();
    for (int i = 0; i < 200; i++) begin
      logic d;
      d = $urandom_range(0,1);
      step(d, i[0], ~d, "R8");
    end
  endtask

  task automatic t_recirculate();
    logic pat [DEPTH];
    do_reset();
    for (int i = 0; i < DEPTH; i++) begin
      pat[i] = $urandom_range(0,1);
      step(pat[i], 1'b0, 1'b0, "R1");
    end
    loop_wire = 1'b1;
    for (int i = 0; i < 3 * DEPTH; i++) begin
      step($urandom_range(0,1), 1'b1, 1'b0, "R7");
      chk("R7", q_out, pat[(i + 1) % DEPTH]);
    end
    loop_wire = 1'b0;
  endtask

  task automatic t_cascade();
    do_reset();
    for (int i = 0; i < 300; i++) begin
      step($urandom_range(0,1), 1'b0, 1'b0, "R1");
      chk("R5", q2_out, exp_at(127));
      chk("R4", q2_out_n, ~q2_out);
    end
  endtask

  task automatic t_reset_midstream();
    do_reset();
    for (int i = 0; i < 100; i++) step(1'b1, 1'b0, 1'b0, "R1");
    chk("R6", q_out, 1'b1);
    do_reset();
    for (int i = 0; i < 63; i++) begin
      step(1'b1, 1'b0, 1'b0, "R6");
      chk("R6", q_out, 1'b0);
    end
    step(1'b1, 1'b0, 1'b0, "R1");
    chk("R1", q_out, 1'b1);
  endtask

  initial begin
    @(negedge clk);
    t_latency_data();
    t_loop_input();
    t_mode_toggle();
    t_recirculate();
    t_cascade();
    t_reset_midstream();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule